// File: doc/BRIEF.md
# Pre-encoded Radix-4 Constant Multiplier

This block multiplies a signed run-time multiplicand by a signed constant taken from an internal coefficient table. The table is filled when the design is built, and its words are already in a non-redundant radix-4 signed-digit form, so there is no recoding logic between the table and the partial-product generators. For an N-bit operand the coefficient has K = N/2 digits. The lower K-1 digits are 2 bits each and take one of four values. The top digit keeps a 3-bit Booth form so that the full two's-complement range is covered. A coefficient word is therefore N+1 bits wide.

Each digit drives one partial-product generator. The K rows are sign-extended, shifted by two bit positions per digit and summed into a 2N-bit result. Negative rows are formed by inverting the row and adding a correction bit at the row's lowest bit. The product is registered, and a valid flag travels beside it with one cycle of latency.

Top module: `nr4sd_cmul`

## Requirements
- R1: One cycle after a clock edge that samples valid_i high, product_o holds the 2N-bit two's-complement product of the signed coefficient stored at addr_i and the signed mcand_i.
- R2: Lower digit j sits at word bits [2j+1:2j] as (hi, lo) and has the value -2*hi + lo, which is one of -2, -1, 0 or +1.
- R3: The top digit sits at word bits [N:N-2] as (neg, two, one) and has the value (-1)^neg * (one + 2*two); one and two are never both set.
- R4: A digit whose value is zero contributes nothing to the sum, including its correction bit.
- R5: The result is exact for the most negative coefficient and for the most negative multiplicand, and for both together.
- R6: valid_o equals the value of valid_i at the previous clock edge.
- R7: When valid_i is low at a clock edge, product_o keeps its value even if addr_i and mcand_i change.
- R8: While rst_ni is low, valid_o and product_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Start a multiplication this cycle |
| addr_i | input | $clog2(DEPTH) | Coefficient table index |
| mcand_i | input | N | Signed multiplicand |
| valid_o | output | 1 | Product register holds a new result |
| product_o | output | 2N | Signed product |

## Verification
A wrong digit decode or a lost correction bit shows up at product_o on the very next cycle, but only for coefficients that contain the affected digit value, so every table entry is combined with every multiplicand value. Sign-handling faults appear first at the extreme operands, where the top row reaches -2 times the most negative multiplicand. A valid or hold fault shows as a missing, extra or changed result in the cycle right after an idle edge.

// File: rtl/nr4sd_pkg.sv
package nr4sd_pkg;
  // lower digit: value = -2*hi + lo
  typedef struct packed {
    logic hi;
    logic lo;
  } nr_dig_t;

  // top digit: value = (-1)^neg * (one + 2*two)
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } booth_dig_t;
endpackage

// File: rtl/nr4sd_coef_rom.sv
module nr4sd_coef_rom #(
  parameter int N     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = N + 1,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [DEPTH*CW-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic [CW-1:0] word_o
);
  logic [CW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = IMAGE[i*CW +: CW];
  end

  assign word_o = (int'(addr_i) < DEPTH) ? mem[addr_i] : '0;
endmodule

// File: rtl/nr4sd_ppg.sv
module nr4sd_ppg
  import nr4sd_pkg::*;
#(
  parameter int N  = 8,
  parameter int RW = N + 2
) (
  input  logic [N-1:0]  mcand_i,
  input  nr_dig_t       dig_i,
  output logic [RW-1:0] row_o,
  output logic          corr_o
);
  logic [RW-1:0] a_ext, mag;

  assign a_ext = {{2{mcand_i[N-1]}}, mcand_i};

  // only three selections: 2A, A or 0; sign from hi
  always_comb begin
    if (dig_i.hi && !dig_i.lo) mag = a_ext << 1;
    else if (dig_i.lo)         mag = a_ext;
    else                       mag = '0;
  end

  assign row_o  = dig_i.hi ? ~mag : mag;
  assign corr_o = dig_i.hi;

  always_comb begin
    if (!dig_i.hi && !dig_i.lo)
      AST_ZERO_DIGIT_SILENT: assert (row_o == '0 && !corr_o); // R4
  end
endmodule

// File: rtl/nr4sd_booth_ppg.sv
module nr4sd_booth_ppg
  import nr4sd_pkg::*;
#(
  parameter int N  = 8,
  parameter int RW = N + 2
) (
  input  logic [N-1:0]  mcand_i,
  input  booth_dig_t    dig_i,
  output logic [RW-1:0] row_o,
  output logic          corr_o
);
  logic [RW-1:0] a_ext, mag;

  assign a_ext = {{2{mcand_i[N-1]}}, mcand_i};

  always_comb begin
    if (dig_i.two)      mag = a_ext << 1;
    else if (dig_i.one) mag = a_ext;
    else                mag = '0;
  end

  assign row_o  = dig_i.neg ? ~mag : mag;
  assign corr_o = dig_i.neg;

  always_comb begin
    AST_TOP_DIGIT_LEGAL: assert (!(dig_i.one && dig_i.two)); // R3
  end
endmodule

// File: rtl/nr4sd_cmul.sv
module nr4sd_cmul
  import nr4sd_pkg::*;
#(
  parameter int N     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [DEPTH*(N+1)-1:0] ROM_INIT = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [N-1:0]    mcand_i,
  output logic            valid_o,
  output logic [2*N-1:0]  product_o
);
  localparam int K  = N / 2;
  localparam int CW = N + 1;
  localparam int RW = N + 2;
  localparam int PW = 2 * N;

  logic [CW-1:0] coef_w;
  logic [RW-1:0] rows [K];
  logic [K-1:0]  corr;
  logic [PW-1:0] sum;

  nr4sd_coef_rom #(.N(N), .DEPTH(DEPTH), .CW(CW), .AW(AW), .IMAGE(ROM_INIT)) u_rom (
    .addr_i (addr_i),
    .word_o (coef_w)
  );

  for (genvar j = 0; j < K - 1; j++) begin : g_low
    nr4sd_ppg #(.N(N), .RW(RW)) u_ppg (
      .mcand_i (mcand_i),
      .dig_i   (nr_dig_t'(coef_w[2*j +: 2])),
      .row_o   (rows[j]),
      .corr_o  (corr[j])
    );
  end

  nr4sd_booth_ppg #(.N(N), .RW(RW)) u_top (
    .mcand_i (mcand_i),
    .dig_i   (booth_dig_t'(coef_w[CW-1 -: 3])),
    .row_o   (rows[K-1]),
    .corr_o  (corr[K-1])
  );

  // sign-extend each row, weight by 4^j, add correction at row LSB
  always_comb begin
    sum = '0;
    for (int j = 0; j < K; j++) begin
      sum = sum + ({{(PW-RW){rows[j][RW-1]}}, rows[j]} << (2*j))
                + (PW'(corr[j]) << (2*j));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      product_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) product_o <= sum;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(product_o)); // R7
endmodule

// File: tb/nr4sd_cmul_tb_top.sv
module nr4sd_cmul_tb_top;
  localparam int N     = 8;
  localparam int K     = N / 2;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = N + 1;

  function automatic int coef_of(int i);
    if (i == 0) return 0;
    if (i == 1) return -(1 << (N-1));
    if (i == 2) return (1 << (N-1)) - 1;
    if (i == 3) return -1;
    return ((i * 45 + 128) % 256) - 128;
  endfunction

  // reference encoder: lower digits from {-2,-1,0,+1}, top digit in Booth form
  function automatic logic [CW-1:0] encode(int val);
    int unsigned bits;
    int c, t, mag;
    logic [CW-1:0] w;
    bits = int'(val) & ((1 << N) - 1);
    c = 0;
    w = '0;
    for (int j = 0; j < K - 1; j++) begin
      t = int'((bits >> (2*j)) & 3) + c;
      case (t)
        0: begin w[2*j+1] = 1'b0; w[2*j] = 1'b0; c = 0; end
        1: begin w[2*j+1] = 1'b0; w[2*j] = 1'b1; c = 0; end
        2: begin w[2*j+1] = 1'b1; w[2*j] = 1'b0; c = 1; end
        3: begin w[2*j+1] = 1'b1; w[2*j] = 1'b1; c = 1; end
        default: begin w[2*j+1] = 1'b0; w[2*j] = 1'b0; c = 1; end
      endcase
    end
    t = -2 * int'((bits >> (N-1)) & 1) + int'((bits >> (N-2)) & 1) + c;
    mag = (t < 0) ? -t : t;
    w[N]   = (t < 0);
    w[N-1] = (mag == 2);
    w[N-2] = (mag == 1);
    return w;
  endfunction

  function automatic logic [DEPTH*CW-1:0] build_rom();
    logic [DEPTH*CW-1:0] img;
    img = '0;
    for (int i = 0; i < DEPTH; i++) img[i*CW +: CW] = encode(coef_of(i));
    return img;
  endfunction

  localparam logic [DEPTH*CW-1:0] ROM_IMG = build_rom();

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          valid_i;
  logic [AW-1:0] addr_i;
  logic [N-1:0]  mcand_i;
  logic          valid_o;
  logic [2*N-1:0] product_o;

  int checks = 0;
  int errors = 0;
  longint exp_q[$];
  string  tag_q[$];

  always #10 clk = ~clk;

  nr4sd_cmul #(.N(N), .DEPTH(DEPTH), .ROM_INIT(ROM_IMG)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .addr_i    (addr_i),
    .mcand_i   (mcand_i),
    .valid_o   (valid_o),
    .product_o (product_o)
  );

  function automatic longint prod_s();
    return longint'($signed(product_o));
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: one transaction per cycle, expectation into the scoreboard
  task automatic drive(int a, int m);
    int c;
    string tag;
    @(negedge clk);
    c = coef_of(a);
    valid_i = 1'b1;
    addr_i  = AW'(a);
    mcand_i = N'(m);
    if (c == -(1 << (N-1)) || m == -(1 << (N-1))) tag = "R5";
    else if (c == 0) tag = "R4";
    else if (c < 0) tag = "R3";
    else if (a == 2) tag = "R2";
    else tag = "R1";
    exp_q.push_back(longint'(c) * longint'(m));
    tag_q.push_back(tag);
  endtask

  // monitor: compare every result as it appears
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 actual valid_o=1 expected no result pending");
      end else begin
        check(tag_q.pop_front(), prod_s(), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    longint last;
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    addr_i  = '0;
    mcand_i = '0;
    repeat (3) @(negedge clk);
    check("R8", longint'(valid_o), 0);
    check("R8", prod_s(), 0);
    rst_ni = 1'b1;

    // R1 R2 R3 R4 R5: every table entry against every multiplicand
    for (int a = 0; a < DEPTH; a++)
      for (int m = -(1 << (N-1)); m < (1 << (N-1)); m++)
        drive(a, m);
    last = longint'(coef_of(DEPTH-1)) * longint'((1 << (N-1)) - 1);

    // R7: idle edge with changed inputs must not disturb the result
    @(negedge clk);
    valid_i = 1'b0;
    addr_i  = AW'(1);
    mcand_i = N'(-(1 << (N-1)));
    @(negedge clk);
    check("R6", longint'(valid_o), 0);
    check("R7", prod_s(), last);
    check("R6", longint'(exp_q.size()), 0);

    // R5: both extremes back-to-back after idle
    drive(1, -(1 << (N-1)));
    drive(1, (1 << (N-1)) - 1);
    drive(2, -(1 << (N-1)));
    @(negedge clk);
    valid_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R6", longint'(exp_q.size()), 0);
    check("R5", prod_s(), longint'(coef_of(2)) * longint'(-(1 << (N-1))));

    // R8: reset mid-stream clears outputs
    rst_ni = 1'b0;
    @(negedge clk);
    check("R8", longint'(valid_o), 0);
    check("R8", prod_s(), 0);
    summary();
  end
endmodule